// File: doc/BRIEF.md
# Conversion Result Serial Output Register

This block holds the most recent 12-bit conversion result and shifts it out one bit at a time, most significant bit first, on a data clock supplied from outside. The data clock arrives as a level input that is sampled on the system clock, and each rising transition seen there moves the output to the next bit. An active-low select gates both the shifting and the output pin. While select is high the pin reads zero, which stands in for a released line.

A new word arrives together with a one-cycle end-of-conversion strobe. The word is accepted only if, at that strobe, the data clock is low or select is high. Otherwise the stored word and the read position stay as they were, the new result is dropped, and a one-cycle refusal pulse is raised. Because the store changes only at an accepted strobe, a host can keep reading the previous result while the next conversion is still running. Once all twelve bits have been presented, the pin reads zero for any further data-clock periods.

Top module: `result_serializer`

## Requirements
- R1: After reset, `sdata` and `load_refused` read 0, and `sdata` stays 0 until the first accepted load.
- R2: A strobe on `conv_done` is accepted when `sclk_in` is 0 or `sel_n` is 1 in that cycle. From the next cycle the stored word is `conv_word` and the position is the MSB (bit 11).
- R3: In a cycle where `sclk_in` is 1, its previous sampled value was 0, and `sel_n` is 0, the position advances by one bit toward the LSB. Bits appear in the order bit 11 down to bit 0.
- R4: A strobe with `sclk_in` = 1 and `sel_n` = 0 is refused. The stored word is unchanged, the new word is lost, and the position moves only as R3 dictates.
- R5: `load_refused` is 1 for exactly the one cycle after a refused strobe and 0 in every other cycle.
- R6: Each of the twelve data-clock periods after a load shows one bit. After the twelfth rising transition `sdata` is 0, and later transitions keep it 0.
- R7: While `sel_n` is 1, `sdata` is 0 and rising transitions of `sclk_in` do not move the position. When `sel_n` returns to 0, the bit that was current reappears.
- R8: An accepted load during a partly read word restarts at the MSB of the new word.
- R9: Without an accepted strobe, the stored word never changes, including while bits are being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_word | input | 12 | Parallel conversion result |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| sclk_in | input | 1 | External data clock, sampled level |
| sel_n | input | 1 | Active-low select |
| sdata | output | 1 | Serial data, MSB first, 0 when idle or deselected |
| load_refused | output | 1 | One-cycle pulse after a refused strobe |

## Verification
The bench strobes a conversion while the data clock is high, including in the same cycle as a rising transition. A design that loaded anyway would show the new MSB, and one that ignored the refusal would not pulse `load_refused`. It also keeps clocking past the twelfth bit, where a design that wrapped around or kept shifting would output stale bits instead of zeros. It toggles select in the middle of a word, where a leaky design would advance the position or drive the pin. Finally, it reloads partway through a read, where a design that failed to clear the position would resume mid-word. A long seeded random run then mixes strobes, clock edges and select changes against a bench model.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned WORD_W_DEF = 12;

  // counter must also hold the "exhausted" value equal to the word width
  function automatic int unsigned cnt_bits(input int unsigned width);
    return $clog2(width + 1);
  endfunction
endpackage

// File: rtl/ser_clk_edge.sv
module ser_clk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic rise
);
  logic sclk_q;
  logic sclk_d;

  assign sclk_d = sclk_in;

  // reset to 1 so a clock already high at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_d;
  end

  assign rise = sclk_in & ~sclk_q;
endmodule

// File: rtl/ser_load_gate.sv
module ser_load_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic sclk_in,
  input  logic sel_n,
  output logic accept,
  output logic refused_pulse
);
  logic refuse_now;
  logic refuse_q;

  always_comb begin
    accept     = conv_done & (~sclk_in | sel_n);
    refuse_now = conv_done & sclk_in & ~sel_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refuse_q <= 1'b0;
    else        refuse_q <= refuse_now;
  end

  assign refused_pulse = refuse_q;
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int unsigned WORD_W = ser_pkg::WORD_W_DEF,
  localparam int unsigned CNT_W = ser_pkg::cnt_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_en,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  pos
);
  localparam logic [CNT_W-1:0] POS_DONE = CNT_W'(WORD_W);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  pos_q, pos_d;

  always_comb begin
    word_d = word_q;
    pos_d  = pos_q;
    if (load_en) begin
      word_d = load_word;
      pos_d  = '0;
    end else if (shift_en && (pos_q != POS_DONE)) begin
      pos_d  = pos_q + 1'b1;
    end
  end

  // position resets to "exhausted" so the pin reads 0 before any load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pos_q  <= POS_DONE;
    end else begin
      word_q <= word_d;
      pos_q  <= pos_d;
    end
  end

  assign word = word_q;
  assign pos  = pos_q;
endmodule

// File: rtl/ser_out_mux.sv
module ser_out_mux #(
  parameter int unsigned WORD_W = ser_pkg::WORD_W_DEF,
  localparam int unsigned CNT_W = ser_pkg::cnt_bits(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  pos,
  input  logic              sel_n,
  output logic              sdata
);
  // ordered[i] is the bit shown at position i; the extra top entry is the idle zero
  logic [WORD_W:0] ordered;

  assign ordered[WORD_W] = 1'b0;
  for (genvar i = 0; i < WORD_W; i++) begin : g_order
    assign ordered[i] = word[WORD_W-1-i];
  end

  assign sdata = ~sel_n & ordered[pos];
endmodule

// File: rtl/result_serializer.sv
module result_serializer #(
  parameter int unsigned WORD_W = ser_pkg::WORD_W_DEF,
  localparam int unsigned CNT_W = ser_pkg::cnt_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              conv_done,
  input  logic              sclk_in,
  input  logic              sel_n,
  output logic              sdata,
  output logic              load_refused
);
  logic              rise;
  logic              accept;
  logic              shift_en;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  pos_q;

  ser_clk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .rise    (rise)
  );

  ser_load_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_done     (conv_done),
    .sclk_in       (sclk_in),
    .sel_n         (sel_n),
    .accept        (accept),
    .refused_pulse (load_refused)
  );

  assign shift_en = rise & ~sel_n;

  ser_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (accept),
    .load_word (conv_word),
    .shift_en  (shift_en),
    .word      (word_q),
    .pos       (pos_q)
  );

  ser_out_mux #(.WORD_W(WORD_W)) u_mux (
    .word  (word_q),
    .pos   (pos_q),
    .sel_n (sel_n),
    .sdata (sdata)
  );
endmodule

// File: rtl/result_serializer_chk.sv
module result_serializer_chk #(
  parameter int unsigned WORD_W = ser_pkg::WORD_W_DEF,
  localparam int unsigned CNT_W = ser_pkg::cnt_bits(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] conv_word,
  input logic              conv_done,
  input logic              sclk_in,
  input logic              sel_n,
  input logic              rise,
  input logic              sdata,
  input logic              load_refused,
  input logic [WORD_W-1:0] word_q,
  input logic [CNT_W-1:0]  pos_q
);
  localparam logic [CNT_W-1:0] POS_DONE = CNT_W'(WORD_W);

  a_r2_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (!sclk_in || sel_n)) |=> (pos_q == '0 && word_q == $past(conv_word)));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !sel_n && rise && pos_q != POS_DONE) |=> (pos_q == CNT_W'($past(pos_q) + 1'b1)));

  a_r4_refused_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && sclk_in && !sel_n) |=> $stable(word_q));

  a_r5_refuse_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && sclk_in && !sel_n) |=> load_refused);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_done && sclk_in && !sel_n) |=> !load_refused);

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == POS_DONE) |-> !sdata);

  a_r7_desel_low: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !sdata);

  a_r7_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !conv_done) |=> $stable(pos_q));

  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(word_q));
endmodule

bind result_serializer result_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_word    (conv_word),
  .conv_done    (conv_done),
  .sclk_in      (sclk_in),
  .sel_n        (sel_n),
  .rise         (rise),
  .sdata        (sdata),
  .load_refused (load_refused),
  .word_q       (word_q),
  .pos_q        (pos_q)
);

// File: tb/result_serializer_bench.sv
`timescale 1ns/1ps
module result_serializer_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] conv_word = '0;
  logic         conv_done = 1'b0;
  logic         sclk_in = 1'b0;
  logic         sel_n = 1'b0;
  logic         sdata;
  logic         load_refused;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [W-1:0] m_word = '0;
  int           m_pos = W;
  logic         m_sclk_prev = 1'b1;

  always #2 clk = ~clk;

  result_serializer u_result_serializer (
    .clk(clk), .rst_n(rst_n), .conv_word(conv_word), .conv_done(conv_done),
    .sclk_in(sclk_in), .sel_n(sel_n), .sdata(sdata), .load_refused(load_refused)
  );

  function automatic logic exp_data(input logic cs_n);
    if (cs_n || m_pos >= W) return 1'b0;
    return m_word[W-1-m_pos];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one system clock: drive, update model at the edge, sample 1 ns later
  task automatic cyc(input string tag, input logic d, input logic [W-1:0] w,
                     input logic s, input logic cs);
    logic exp_ref;
    logic acc;
    logic rs;
    conv_done = d; conv_word = w; sclk_in = s; sel_n = cs;
    @(posedge clk);
    exp_ref = d & s & ~cs;
    acc     = d & (~s | cs);
    rs      = s & ~m_sclk_prev;
    m_sclk_prev = s;
    if (acc) begin
      m_word = w; m_pos = 0;
    end else if (rs && !cs && m_pos < W) begin
      m_pos++;
    end
    #1;
    check({tag, " sdata"}, sdata, exp_data(cs));
    check("R5 refuse pulse", load_refused, exp_ref);
  endtask

  task automatic clk_pulse(input string tag, input logic cs);
    cyc(tag, 1'b0, '0, 1'b1, cs);
    cyc(tag, 1'b0, '0, 1'b0, cs);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset sdata", sdata, 1'b0);
    check("R1 reset refused", load_refused, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: clocking before any load leaves the pin low
    for (int i = 0; i < 3; i++) clk_pulse("R1", 1'b0);

    // R2/R3/R6: load, read all bits, then clock beyond the word
    cyc("R2", 1'b1, 12'hA5C, 1'b0, 1'b0);
    for (int i = 0; i < W; i++) clk_pulse("R3", 1'b0);
    for (int i = 0; i < 3; i++) clk_pulse("R6", 1'b0);

    // R4/R5: load, read 3 bits, refuse while the clock is high (same cycle as an edge)
    cyc("R2", 1'b1, 12'h3C9, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) clk_pulse("R9", 1'b0);
    cyc("R4", 1'b1, 12'hFFF, 1'b1, 1'b0);
    cyc("R4", 1'b0, '0, 1'b1, 1'b0);
    cyc("R4", 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) clk_pulse("R4", 1'b0);

    // R7: deselect mid-word, clock edges ignored, then resume
    for (int i = 0; i < 3; i++) clk_pulse("R7", 1'b1);
    cyc("R7", 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) clk_pulse("R7", 1'b0);

    // R2: accepted with clock high because select is high
    cyc("R2", 1'b1, 12'h801, 1'b1, 1'b1);
    cyc("R2", 1'b0, '0, 1'b1, 1'b1);
    cyc("R2", 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) clk_pulse("R3", 1'b0);

    // R8: reload partway through restarts at the MSB
    cyc("R8", 1'b1, 12'h6B3, 1'b0, 1'b0);
    for (int i = 0; i < W + 1; i++) clk_pulse("R8", 1'b0);

    // seeded random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic d, s, cs;
      logic [W-1:0] w;
      d  = (($urandom % 16) == 0);
      s  = $urandom % 2;
      cs = (($urandom % 8) == 0);
      w  = W'($urandom);
      cyc("R9 random", d, w, s, cs);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule